// File: doc/BRIEF.md
# Privilege Check and Program Trap Entry

This block sits at the issue stage of a 64-bit core. For each decoded instruction it first checks whether the instruction is privileged and the machine is in problem (user) state. It then checks whether the decoder flagged the encoding as illegal, and finally whether the instruction is a permitted halt request. It reports the outcome one cycle later. The outcome is one of four: the instruction may commit, a program trap is entered, the core halts, or nothing happens.

On a trap the block performs the full architectural entry. It saves the address of the trapping instruction and a tagged copy of the machine state register. It applies one fixed rewrite to the live machine state register and redirects fetch to the program interrupt vector. The write enables it produces drive the save/restore registers, the machine state register and the fetch address in the surrounding core. A sticky halted flag blocks all further issue until reset.

Top module: `ptrap_unit`

## Requirements
- R1: Opcode classes on `opc_i` are: 1 halt, 2 read-MSR, 3 write-MSR, 4 write-MSR-doubleword, 5 interrupt-return, 6 read-SPR, 7 write-SPR; all other values are ordinary. Classes 1 to 5 are always privileged. Classes 6 and 7 are privileged only when `insn_b20_i` is 1.
- R2: A valid privileged instruction with `msr_i[14]` (problem state) equal to 1 gives `trap_we_o`=1 and `exec_o`=0 in the cycle after the strobe.
- R3: A valid instruction with `illegal_i`=1 takes the same trap when the privilege check does not fire. The privilege trap has priority over the illegal trap, and both have priority over halt.
- R4: On a trap, `srr0_o` equals the `cia_i` of the trapping instruction (not CIA+4). `srr1_o` equals `msr_i` with bit 18 set for a privilege trap or bit 19 set for an illegal trap; every other bit is copied unchanged.
- R5: On a trap, `nia_we_o`=1 and `nia_o`=0x700 for both trap kinds.
- R6: On a trap, `msr_o` equals `msr_i` with bits 1,2,3,4,5,8,9,10,11,13,14,15,23,25,32 cleared and bits 0 and 63 set. All remaining bits are preserved.
- R7: A permitted halt instruction sets `halted_o` in the following cycle with no trap, no commit and no fetch redirect. `halted_o` stays 1 until reset.
- R8: While `halted_o` is 1, valid strobes are ignored: no trap, commit or fetch write, and `srr0_o`, `srr1_o`, `msr_o` keep their values.
- R9: A permitted non-halt instruction gives `exec_o`=1, `nia_we_o`=1 and `nia_o`=`nia_i`, with `trap_we_o`=0 and the saved-state outputs unchanged.
- R10: A cycle without `valid_i` leaves `trap_we_o`, `exec_o` and `nia_we_o` at 0 in the next cycle.
- R11: Reset (`rst_ni` low) clears all outputs, including `halted_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decoded instruction present this cycle |
| opc_i | input | 4 | Decoded opcode class (R1) |
| insn_b20_i | input | 1 | Bit 20 of the raw instruction word |
| illegal_i | input | 1 | Decoder found no legal mnemonic |
| cia_i | input | 64 | Address of the current instruction |
| nia_i | input | 64 | Sequential next address |
| msr_i | input | 64 | Current machine state register |
| trap_we_o | output | 1 | Write SRR0, SRR1 and MSR from the outputs below |
| exec_o | output | 1 | Instruction may commit |
| nia_we_o | output | 1 | Load fetch address from nia_o |
| nia_o | output | 64 | Next fetch address |
| srr0_o | output | 64 | Saved instruction address |
| srr1_o | output | 64 | Saved machine state with reason bit |
| msr_o | output | 64 | Machine state after trap entry |
| halted_o | output | 1 | Sticky halt flag |

## Verification
The assertions check on every cycle that trap and commit never coincide and that a trap always redirects to 0x700 with the fixed MSR bits in place. They also check that an always-privileged class in problem state or an illegal flag leads to a trap saving the right address and reason. Finally, they check that the halted flag is sticky and that a halted or idle unit issues no strobes. Only the bench scenarios show the exact bit-wise MSR rewrite against arbitrary input patterns, and the bit-20 qualification for SPR moves. The same holds for the priority order when several conditions meet, and for the saved outputs holding across non-trap and halted cycles.

// File: rtl/ptrap_pkg.sv
package ptrap_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_HALT    = 4'd1;
  localparam logic [OPC_W-1:0] OPC_RD_MSR  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_WR_MSR  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_WR_MSRD = 4'd4;
  localparam logic [OPC_W-1:0] OPC_INT_RET = 4'd5;
  localparam logic [OPC_W-1:0] OPC_RD_SPR  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_WR_SPR  = 4'd7;

  // machine state bit positions, LSB-0
  localparam int unsigned B_LE   = 0;
  localparam int unsigned B_RI   = 1;
  localparam int unsigned B_PMM  = 2;
  localparam int unsigned B_UND  = 3;
  localparam int unsigned B_DR   = 4;
  localparam int unsigned B_IR   = 5;
  localparam int unsigned B_FE1  = 8;
  localparam int unsigned B_TE_E = 9;
  localparam int unsigned B_TE_S = 10;
  localparam int unsigned B_FE0  = 11;
  localparam int unsigned B_FP   = 13;
  localparam int unsigned B_PR   = 14;
  localparam int unsigned B_EE   = 15;
  localparam int unsigned B_VSX  = 23;
  localparam int unsigned B_VEC  = 25;
  localparam int unsigned B_TM   = 32;
  localparam int unsigned B_SF   = 63;

  // saved-state reason bits
  localparam int unsigned B_WHY_PRIV = 18;
  localparam int unsigned B_WHY_ILL  = 19;

  localparam logic [XLEN-1:0] TRAP_VEC = 64'h700;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_EXEC = 2'd1,
    ACT_TRAP = 2'd2,
    ACT_HALT = 2'd3
  } act_e;

  typedef enum logic {
    WHY_PRIV = 1'b0,
    WHY_ILL  = 1'b1
  } why_e;

  function automatic logic [XLEN-1:0] msr_clr_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[B_IR] = 1'b1;  m[B_DR] = 1'b1;  m[B_FE0] = 1'b1; m[B_FE1] = 1'b1;
    m[B_EE] = 1'b1;  m[B_RI] = 1'b1;  m[B_TM] = 1'b1;  m[B_VEC] = 1'b1;
    m[B_VSX] = 1'b1; m[B_PR] = 1'b1;  m[B_FP] = 1'b1;  m[B_PMM] = 1'b1;
    m[B_TE_S] = 1'b1; m[B_TE_E] = 1'b1; m[B_UND] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] msr_set_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[B_SF] = 1'b1;
    m[B_LE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ptrap_classify.sv
module ptrap_classify
  import ptrap_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic             insn_b20_i,
  output logic             priv_o,
  output logic             halt_o
);
  logic always_priv, spr_move;

  always_comb begin
    always_priv = 1'b0;
    spr_move    = 1'b0;
    unique case (opc_i)
      OPC_HALT, OPC_RD_MSR, OPC_WR_MSR,
      OPC_WR_MSRD, OPC_INT_RET:  always_priv = 1'b1;
      OPC_RD_SPR, OPC_WR_SPR:    spr_move    = 1'b1;
      default: ;
    endcase
  end

  assign priv_o = always_priv | (spr_move & insn_b20_i);
  assign halt_o = (opc_i == OPC_HALT);
endmodule

// File: rtl/ptrap_arbiter.sv
module ptrap_arbiter
  import ptrap_pkg::*;
(
  input  logic valid_i,
  input  logic halted_i,
  input  logic priv_i,
  input  logic pr_i,
  input  logic illegal_i,
  input  logic halt_req_i,
  output act_e act_o,
  output why_e why_o
);
  // priority: privilege > illegal > halt > commit
  always_comb begin
    act_o = ACT_NONE;
    why_o = WHY_PRIV;
    if (valid_i && !halted_i) begin
      if (priv_i && pr_i) begin
        act_o = ACT_TRAP;
        why_o = WHY_PRIV;
      end else if (illegal_i) begin
        act_o = ACT_TRAP;
        why_o = WHY_ILL;
      end else if (halt_req_i) begin
        act_o = ACT_HALT;
      end else begin
        act_o = ACT_EXEC;
      end
    end
  end
endmodule

// File: rtl/ptrap_msr_xform.sv
module ptrap_msr_xform
  import ptrap_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  input  why_e            why_i,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o
);
  localparam logic [XLEN-1:0] CLR = msr_clr_mask();
  localparam logic [XLEN-1:0] SET = msr_set_mask();

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign msr_o[i] = SET[i] | (msr_i[i] & ~CLR[i]);
    if (i == B_WHY_PRIV) begin : g_why_priv
      assign srr1_o[i] = msr_i[i] | (why_i == WHY_PRIV);
    end else if (i == B_WHY_ILL) begin : g_why_ill
      assign srr1_o[i] = msr_i[i] | (why_i == WHY_ILL);
    end else begin : g_copy
      assign srr1_o[i] = msr_i[i];
    end
  end
endmodule

// File: rtl/ptrap_unit.sv
module ptrap_unit
  import ptrap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       opc_i,
  input  logic             insn_b20_i,
  input  logic             illegal_i,
  input  logic [63:0]      cia_i,
  input  logic [63:0]      nia_i,
  input  logic [63:0]      msr_i,
  output logic             trap_we_o,
  output logic             exec_o,
  output logic             nia_we_o,
  output logic [63:0]      nia_o,
  output logic [63:0]      srr0_o,
  output logic [63:0]      srr1_o,
  output logic [63:0]      msr_o,
  output logic             halted_o
);
  logic            priv, halt_req;
  act_e            act;
  why_e            why;
  logic [XLEN-1:0] srr1_nxt, msr_nxt;

  ptrap_classify u_cls (
    .opc_i      (opc_i),
    .insn_b20_i (insn_b20_i),
    .priv_o     (priv),
    .halt_o     (halt_req)
  );

  ptrap_arbiter u_arb (
    .valid_i    (valid_i),
    .halted_i   (halted_o),
    .priv_i     (priv),
    .pr_i       (msr_i[B_PR]),
    .illegal_i  (illegal_i),
    .halt_req_i (halt_req),
    .act_o      (act),
    .why_o      (why)
  );

  ptrap_msr_xform u_xf (
    .msr_i  (msr_i),
    .why_i  (why),
    .srr1_o (srr1_nxt),
    .msr_o  (msr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_we_o <= 1'b0;
      exec_o    <= 1'b0;
      nia_we_o  <= 1'b0;
      nia_o     <= '0;
      srr0_o    <= '0;
      srr1_o    <= '0;
      msr_o     <= '0;
      halted_o  <= 1'b0;
    end else begin
      trap_we_o <= (act == ACT_TRAP);
      exec_o    <= (act == ACT_EXEC);
      nia_we_o  <= (act == ACT_TRAP) || (act == ACT_EXEC);
      if (act == ACT_HALT) halted_o <= 1'b1;
      if (act == ACT_EXEC) nia_o <= nia_i;
      if (act == ACT_TRAP) begin
        nia_o  <= TRAP_VEC;
        srr0_o <= cia_i;
        srr1_o <= srr1_nxt;
        msr_o  <= msr_nxt;
      end
    end
  end
endmodule

// File: rtl/ptrap_unit_chk.sv
module ptrap_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [3:0]  opc_i,
  input logic        illegal_i,
  input logic [63:0] cia_i,
  input logic [63:0] msr_i,
  input logic        trap_we_o,
  input logic        exec_o,
  input logic        nia_we_o,
  input logic [63:0] nia_o,
  input logic [63:0] srr0_o,
  input logic [63:0] srr1_o,
  input logic [63:0] msr_o,
  input logic        halted_o
);
  logic live, always_priv;
  assign live        = valid_i && !halted_o;
  assign always_priv = (opc_i >= 4'd1) && (opc_i <= 4'd5);

  p_trap_or_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_we_o && exec_o));

  p_priv_trap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && always_priv && msr_i[14] |=> trap_we_o && srr1_o[18] && !exec_o);

  p_ill_trap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && illegal_i |=> trap_we_o);

  p_srr0_cia_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && illegal_i |=> srr0_o == $past(cia_i));

  p_vector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_we_o |-> nia_we_o && nia_o == 64'h700);

  p_msr_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_we_o |-> msr_o[63] && msr_o[0] && !msr_o[14] && !msr_o[15]);

  p_halt_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  p_halted_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> !trap_we_o && !exec_o && !nia_we_o && $stable(srr0_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !trap_we_o && !exec_o && !nia_we_o);
endmodule

bind ptrap_unit ptrap_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .opc_i     (opc_i),
  .illegal_i (illegal_i),
  .cia_i     (cia_i),
  .msr_i     (msr_i),
  .trap_we_o (trap_we_o),
  .exec_o    (exec_o),
  .nia_we_o  (nia_we_o),
  .nia_o     (nia_o),
  .srr0_o    (srr0_o),
  .srr1_o    (srr1_o),
  .msr_o     (msr_o),
  .halted_o  (halted_o)
);

// File: tb/ptrap_unit_test.sv
module ptrap_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  opc_i = '0;
  logic        insn_b20_i = 1'b0;
  logic        illegal_i = 1'b0;
  logic [63:0] cia_i = '0, nia_i = '0, msr_i = '0;
  logic        trap_we_o, exec_o, nia_we_o, halted_o;
  logic [63:0] nia_o, srr0_o, srr1_o, msr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit          m_halt = 0;
  logic [63:0] m_srr0 = '0, m_srr1 = '0, m_msr = '0, m_nia = '0;

  ptrap_unit uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic bit m_priv(input logic [3:0] op, input logic b20);
    return (op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5}) || ((op == 4'd6 || op == 4'd7) && b20);
  endfunction

  function automatic logic [63:0] m_newmsr(input logic [63:0] m);
    logic [63:0] clr, set;
    clr = (64'd1<<32) | (64'd1<<25) | (64'd1<<23) | (64'd1<<15) | (64'd1<<14)
        | (64'd1<<13) | (64'd1<<11) | (64'd1<<10) | (64'd1<<9) | (64'd1<<8)
        | (64'd1<<5) | (64'd1<<4) | (64'd1<<3) | (64'd1<<2) | (64'd1<<1);
    set = (64'd1<<63) | 64'd1;
    return (m & ~clr) | set;
  endfunction

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic run_vec(input logic [3:0] op, input logic b20, input logic ill,
                         input logic [63:0] cia, input logic [63:0] nia,
                         input logic [63:0] msr, input string rq);
    bit e_trap, e_exec, e_halt;
    e_trap = 0; e_exec = 0; e_halt = 0;
    if (!m_halt) begin
      if (m_priv(op, b20) && msr[14]) begin
        e_trap = 1; m_srr1 = msr | (64'd1<<18);
      end else if (ill) begin
        e_trap = 1; m_srr1 = msr | (64'd1<<19);
      end else if (op == 4'd1) e_halt = 1;
      else e_exec = 1;
      if (e_trap) begin m_srr0 = cia; m_msr = m_newmsr(msr); m_nia = 64'h700; end
      if (e_exec) m_nia = nia;
    end
    valid_i = 1; opc_i = op; insn_b20_i = b20; illegal_i = ill;
    cia_i = cia; nia_i = nia; msr_i = msr;
    @(negedge clk_i);
    valid_i = 0;
    if (e_halt) m_halt = 1;
    check(trap_we_o == e_trap, rq, 64'(trap_we_o), 64'(e_trap));
    check(exec_o == e_exec, rq, 64'(exec_o), 64'(e_exec));
    check(nia_we_o == (e_trap | e_exec), rq, 64'(nia_we_o), 64'(e_trap | e_exec));
    check(halted_o == m_halt, "R7", 64'(halted_o), 64'(m_halt));
    if (e_trap | e_exec) check(nia_o == m_nia, "R5", nia_o, m_nia);
    check(srr0_o == m_srr0, "R4 srr0", srr0_o, m_srr0);
    check(srr1_o == m_srr1, "R4 srr1", srr1_o, m_srr1);
    check(msr_o == m_msr, "R6", msr_o, m_msr);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check({trap_we_o, exec_o, nia_we_o, halted_o} == 4'b0, "R11", 64'({trap_we_o, exec_o, nia_we_o, halted_o}), 0);
    check((nia_o | srr0_o | srr1_o | msr_o) == 0, "R11", nia_o | srr0_o | srr1_o | msr_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 every class with both bit-20 values in problem state
    for (int op = 0; op < 16; op++)
      for (int b = 0; b < 2; b++)
        run_vec(4'(op), 1'(b), 1'b0, 64'h1000 + 64'(op*8+b*4), 64'h2000, 64'h4000, "R1");

    // R2 / R3 priority: privileged and illegal together
    run_vec(4'd3, 1'b0, 1'b1, 64'hAAAA_0000_0000_1234, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, "R3 prio");
    run_vec(4'd6, 1'b1, 1'b1, 64'h10, 64'h14, 64'h0000_0000_0008_4000, "R2");
    // illegal in supervisor state with bit 18 already set in MSR
    run_vec(4'd2, 1'b0, 1'b1, 64'h20, 64'h24, 64'h0004_0000, "R3");
    // SPR move with bit 20 clear in problem state commits
    run_vec(4'd7, 1'b0, 1'b0, 64'h30, 64'h34, 64'h4000, "R9");
    // all-zero MSR trap: only SF and LE come up
    run_vec(4'd0, 1'b0, 1'b1, 64'h40, 64'h44, 64'h0, "R6");

    // R10 idle cycle
    @(negedge clk_i);
    check({trap_we_o, exec_o, nia_we_o} == 3'b0, "R10", 64'({trap_we_o, exec_o, nia_we_o}), 0);

    // constrained random, halt only via privileged-in-user or illegal path
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  op;
      logic [63:0] m;
      logic        il;
      op = 4'($urandom_range(0, 15));
      m  = {$urandom, $urandom};
      il = ($urandom_range(0, 3) == 0);
      if (op == 4'd1 && !m[14] && !il) op = 4'd0;
      run_vec(op, 1'($urandom), il, {$urandom, $urandom}, {$urandom, $urandom}, m, "R2/R3/R9 rnd");
    end

    // R7 permitted halt
    run_vec(4'd1, 1'b0, 1'b0, 64'h500, 64'h504, 64'h0, "R7");
    // R8 halted: trap-worthy and ordinary strobes ignored
    run_vec(4'd2, 1'b0, 1'b1, 64'h600, 64'h604, 64'h4000, "R8");
    run_vec(4'd0, 1'b0, 1'b0, 64'h700, 64'h704, 64'h0, "R8");

    // reset clears halt
    rst_ni = 0;
    @(negedge clk_i);
    check(halted_o == 1'b0, "R11", 64'(halted_o), 0);
    check(srr0_o == 0, "R11", srr0_o, 0);
    rst_ni = 1;
    m_halt = 0; m_srr0 = 0; m_srr1 = 0; m_msr = 0; m_nia = 0;
    @(negedge clk_i);
    run_vec(4'd0, 1'b0, 1'b0, 64'h800, 64'h804, 64'h0, "R9 after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule